// File: doc/BRIEF.md
# Edge-Counting Timer with Capture Clear

This block is a 32-bit counter that runs from a fast system clock. In timer mode it advances on every clock while it is enabled. In counter mode it watches one of several external inputs and advances only when that input shows the chosen kind of transition. The block samples each external input on the system clock and classifies every cycle as a rising transition, a falling transition or no change. Because of this, an input level must last at least one system clock period. The fastest input that can be counted runs at half the clock rate.

Two further edge triggers can be set up independently, each with its own input and polarity. The clear trigger forces the counter to zero. The capture trigger copies the counter into a holding register. Set the clear on the leading edge of a pulse and the capture on its trailing edge: the holding register then gives the pulse length with no arithmetic afterwards. All settings are plain input ports, intended to be driven from a register bank elsewhere on the chip.

Top module: `edge_count_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, `count` and `capture` are zero.
- R2: When `mode` is 00 (timer) and `en` is 1, `count` increases by one on every clock.
- R3: When `en` is 0, `count` keeps its value, whatever happens on the inputs.
- R4: When `mode` is 01, `count` increases by one for each rising transition of `ext_in[cnt_sel]`. The new value is visible after the third rising clock edge that follows the input change. Falling transitions have no effect.
- R5: When `mode` is 10, only falling transitions of the selected input advance `count`.
- R6: When `mode` is 11, both kinds of transition advance `count`. This holds even when the input toggles on every clock.
- R7: Activity on inputs other than `ext_in[cnt_sel]` does not change `count` in counter mode.
- R8: `count` wraps from its all-ones value to zero.
- R9: With `clr_en` set, a transition of `ext_in[clr_sel]` of polarity `clr_edge` (0 rising, 1 falling) sets `count` to zero, with the same latency as R4. When `en` is 1, a clear and an increment in the same cycle give zero.
- R10: With `cap_en` set, a transition of `ext_in[cap_sel]` of polarity `cap_edge` (0 rising, 1 falling) loads `capture` with the value `count` held just before that clock edge. This is also the value before any clear taken on the same edge. `capture` keeps its value at all other times.
- R11: In timer mode, with the clear set to the rising edge and the capture set to the falling edge of the same input, a high pulse lasting H clocks leaves H-1 in `capture`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable |
| mode | input | 2 | 00 timer, 01 rising, 10 falling, 11 both edges |
| cnt_sel | input | 2 | Input that feeds the counter in counter mode |
| clr_en | input | 1 | Enables clear-on-edge |
| clr_sel | input | 2 | Input used by the clear trigger |
| clr_edge | input | 1 | Clear polarity: 0 rising, 1 falling |
| cap_en | input | 1 | Enables capture-on-edge |
| cap_sel | input | 2 | Input used by the capture trigger |
| cap_edge | input | 1 | Capture polarity: 0 rising, 1 falling |
| ext_in | input | 4 | Asynchronous external inputs |
| count | output | 32 | Counter value |
| capture | output | 32 | Captured counter value |

## Verification
The bound assertions check the cycle-level relations on every clock:
- `count` holds while disabled.
- `count` steps by exactly one in timer mode.
- `count` stays put in counter mode when no matching transition is seen.
- A clear always leaves zero.
- `capture` changes only on its trigger, and then to the preceding `count`.

The exact three-edge latency from a pin change, the routing of each trigger to its selected input and polarity, counting at the half-rate limit, and the H-1 pulse measurement can only be shown by the bench's scenarios. Wrap-around is shown the same way, on a narrow instance.

// File: rtl/ect_pkg.sv
package ect_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } cnt_mode_e;

  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } edge_pol_e;

  // Does this cycle advance the counter under the given mode?
  function automatic logic mode_hit(cnt_mode_e m, logic r, logic f);
    logic hit;
    case (m)
      MODE_TIMER: hit = 1'b1;
      MODE_RISE:  hit = r;
      MODE_FALL:  hit = f;
      default:    hit = r | f;
    endcase
    return hit;
  endfunction

  // Pick the transition of one polarity.
  function automatic logic pol_hit(edge_pol_e p, logic r, logic f);
    return (p == POL_FALL) ? f : r;
  endfunction

endpackage

// File: rtl/ect_sync.sv
module ect_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, meta_d;
    logic sync_q, sync_d;

    always_comb begin
      meta_d = d[i];
      sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
      end
    end

    assign q[i] = sync_q;
  end

endmodule

// File: rtl/ect_edge_det.sv
module ect_edge_det #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  // One history bit per input, so switching the selection never
  // creates a transition out of two different inputs.
  always_comb begin
    prev_d = d;
    rise   = d & ~prev_q;
    fall   = ~d & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (clr)      cnt_d = '0;
      else if (inc) cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/edge_count_timer.sv
module edge_count_timer
  import ect_pkg::*;
#(
  parameter  int unsigned CNT_W = 32,
  parameter  int unsigned N_IN  = 4,
  localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] cnt_sel,
  input  logic             clr_en,
  input  logic [SEL_W-1:0] clr_sel,
  input  logic             clr_edge,
  input  logic             cap_en,
  input  logic [SEL_W-1:0] cap_sel,
  input  logic             cap_edge,
  input  logic [N_IN-1:0]  ext_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture
);

  logic [N_IN-1:0]  sync_in;
  logic [N_IN-1:0]  rise_v;
  logic [N_IN-1:0]  fall_v;
  logic             inc_hit;
  logic             clr_hit;
  logic             cap_hit;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cap_d;

  ect_sync #(.WIDTH(N_IN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_in),
    .q     (sync_in)
  );

  ect_edge_det #(.WIDTH(N_IN)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_in),
    .rise  (rise_v),
    .fall  (fall_v)
  );

  // Event classification against the three trigger settings.
  always_comb begin
    inc_hit = mode_hit(cnt_mode_e'(mode), rise_v[cnt_sel], fall_v[cnt_sel]);
    clr_hit = clr_en & pol_hit(edge_pol_e'(clr_edge), rise_v[clr_sel], fall_v[clr_sel]);
    cap_hit = cap_en & pol_hit(edge_pol_e'(cap_edge), rise_v[cap_sel], fall_v[cap_sel]);
  end

  ect_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .inc   (inc_hit),
    .clr   (clr_hit),
    .cnt   (count)
  );

  // Capture takes the value present before this edge's update.
  always_comb begin
    cap_d = cap_q;
    if (cap_hit) cap_d = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign capture = cap_q;

endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic             inc_hit,
  input logic             clr_hit,
  input logic             cap_hit,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count)); // R3

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00 && !clr_hit) |=> (count == $past(count) + ONE)); // R2

  AST_NO_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !inc_hit && !clr_hit) |=> $stable(count)); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_hit) |=> (count == '0)); // R9

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (capture == $past(count))); // R10

  AST_CAPTURE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(capture)); // R10

endmodule

bind edge_count_timer ect_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .mode    (mode),
  .inc_hit (inc_hit),
  .clr_hit (clr_hit),
  .cap_hit (cap_hit),
  .count   (count),
  .capture (capture)
);

// File: tb/edge_count_timer_tb.sv
`timescale 1ns/1ps
module edge_count_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [1:0]  mode;
  logic [1:0]  cnt_sel, clr_sel, cap_sel;
  logic        clr_en, clr_edge, cap_en, cap_edge;
  logic [3:0]  ext_in;
  logic [31:0] count, capture;
  logic [7:0]  count_w8, capture_w8;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  edge_count_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt_sel(cnt_sel),
    .clr_en(clr_en), .clr_sel(clr_sel), .clr_edge(clr_edge),
    .cap_en(cap_en), .cap_sel(cap_sel), .cap_edge(cap_edge),
    .ext_in(ext_in), .count(count), .capture(capture)
  );

  edge_count_timer #(.CNT_W(8)) u_dut_w8 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt_sel(cnt_sel),
    .clr_en(clr_en), .clr_sel(clr_sel), .clr_edge(clr_edge),
    .cap_en(cap_en), .cap_sel(cap_sel), .cap_edge(cap_edge),
    .ext_in(ext_in), .count(count_w8), .capture(capture_w8)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Each step moves from one falling clock edge to the next.
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    ext_in = '0; en = 1'b0; mode = 2'b00; cnt_sel = '0;
    clr_en = 1'b0; clr_sel = '0; clr_edge = 1'b0;
    cap_en = 1'b0; cap_sel = '0; cap_edge = 1'b0;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count", count, 0);
    check("R1 capture", capture, 0);
  endtask

  task automatic t_timer();
    do_reset();
    en = 1'b1;
    step(5);
    check("R2 timer 5 clocks", count, 5);
    en = 1'b0;
    ext_in = 4'hF;
    step(4);
    check("R3 hold while disabled", count, 5);
    ext_in = 4'h0;
    step(3);
    en = 1'b1;
    step(1);
    check("R2 resume", count, 6);
  endtask

  task automatic t_rise();
    do_reset();
    mode = 2'b01; cnt_sel = 2'd2; en = 1'b1;
    ext_in[2] = 1'b1;
    step(2);
    check("R4 before latency", count, 0);
    step(1);
    check("R4 third edge", count, 1);
    ext_in[2] = 1'b0;
    step(4);
    check("R4 falling ignored", count, 1);
    for (int i = 0; i < 4; i++) begin
      ext_in[0] = ~ext_in[0]; step(2);
      ext_in[1] = ~ext_in[1]; step(2);
    end
    step(3);
    check("R7 other inputs ignored", count, 1);
    for (int i = 0; i < 3; i++) begin
      ext_in[2] = 1'b1; step(2);
      ext_in[2] = 1'b0; step(2);
    end
    step(3);
    check("R4 several rises", count, 4);
  endtask

  task automatic t_fall();
    do_reset();
    mode = 2'b10; cnt_sel = 2'd1; en = 1'b1;
    ext_in[1] = 1'b1;
    step(4);
    check("R5 rise ignored", count, 0);
    ext_in[1] = 1'b0;
    step(3);
    check("R5 fall counted", count, 1);
  endtask

  task automatic t_both();
    do_reset();
    mode = 2'b11; cnt_sel = 2'd3; en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ext_in[3] = ~ext_in[3]; step(3);
    end
    check("R6 both edges", count, 3);
    for (int i = 0; i < 6; i++) begin
      ext_in[3] = ~ext_in[3]; step(1);
    end
    step(3);
    check("R6 half clock rate", count, 9);
  endtask

  task automatic t_clear();
    do_reset();
    en = 1'b1; clr_en = 1'b1; clr_sel = 2'd0; clr_edge = 1'b0;
    step(10);
    check("R9 precount", count, 10);
    ext_in[0] = 1'b1;
    step(3);
    check("R9 rise clear beats timer", count, 0);
    step(2);
    check("R9 runs after clear", count, 2);
    clr_edge = 1'b1;
    ext_in[0] = 1'b0;
    step(3);
    check("R9 fall clear", count, 0);
    mode = 2'b11; clr_edge = 1'b0;
    ext_in[0] = 1'b1; step(3);
    check("R9 clear beats edge count", count, 0);
    ext_in[0] = 1'b0; step(3);
    check("R9 fall still counts", count, 1);
  endtask

  task automatic t_capture();
    do_reset();
    en = 1'b1; cap_en = 1'b1; cap_sel = 2'd3; cap_edge = 1'b0;
    step(7);
    ext_in[3] = 1'b1;
    step(3);
    check("R10 captured value", capture, 9);
    check("R10 count continues", count, 10);
    ext_in[3] = 1'b0;
    step(3);
    check("R10 other polarity ignored", capture, 9);
    clr_en = 1'b1; clr_sel = 2'd3; clr_edge = 1'b0;
    ext_in[3] = 1'b1;
    step(3);
    check("R10 capture before clear", capture, 15);
    check("R9 same edge clears", count, 0);
  endtask

  task automatic t_width(input int h);
    do_reset();
    en = 1'b1;
    clr_en = 1'b1; clr_sel = 2'd1; clr_edge = 1'b0;
    cap_en = 1'b1; cap_sel = 2'd1; cap_edge = 1'b1;
    step(5);
    ext_in[1] = 1'b1;
    step(h);
    ext_in[1] = 1'b0;
    step(4);
    check("R11 pulse width", capture, h - 1);
  endtask

  task automatic t_wrap();
    do_reset();
    en = 1'b1;
    step(256);
    check("R8 narrow wraps to zero", {24'd0, count_w8}, 0);
    check("R8 wide keeps counting", count, 256);
    step(5);
    check("R8 after wrap", {24'd0, count_w8}, 5);
  endtask

  initial begin
    t_reset();
    t_timer();
    t_rise();
    t_fall();
    t_both();
    t_clear();
    t_capture();
    t_width(7);
    t_width(1);
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule